// File: doc/BRIEF.md
# Fixed-Ratio Block Read Buffer Pool

This block holds a small pool of block-sized read buffers between a system side and a cache side. Both sides run in synchronous clock domains at fixed integer ratios to one base clock. The block generates a tick for each domain from that base clock: `sys_tick` marks a system-side edge and `cache_tick` marks a cache-side edge. Each side's inputs are sampled only on its own tick. The system side cannot be flow-controlled. For that reason a buffer is reserved before its block read request is issued, and every fill beat that arrives afterwards is accepted without back-pressure.

A fill of `BLOCK_BYTES` arrives as `BEATS` beats of `BEAT_BYTES` each. After its last beat the buffer is complete, but the cache side learns this only at the next edge shared by both domains. The cache side drains buffers strictly in reservation order, one beat per cache tick, and the buffer returns to the pool on its final unload beat. A fill aimed at a buffer that was never reserved is dropped and reported. So is a fill aimed at a buffer that is complete but not yet drained.

Top module: `rbp_read_pool`

## Requirements
- R1: After reset every buffer is free, `rsv_avail` is 1, `rsv_id` is 0, and `buf_ready`, `head_ready`, `unld_valid`, `err_unrsvd` and `err_ovwr` are all 0.
- R2: On a base edge with `sys_tick` and `rsv_req` both high, the lowest-indexed free buffer is reserved and appended to the unload order. `rsv_avail` is 0 exactly when no buffer is free, and a request made then has no effect.
- R3: On a system tick with `fill_valid` high and `fill_id` naming a reserved buffer, `fill_data` is stored as that buffer's next beat, counting from beat 0. The `BEATS`-th such beat makes the buffer complete.
- R4: Bit i of `buf_ready` changes only on a common edge, where base phase 0 is both a system and a cache tick. On that edge it takes the value of whether buffer i was complete before the edge.
- R5: Unloading follows reservation order. With `cache_tick`, `unld_req` and `head_ready` all high, one cycle later `unld_valid` is 1 and `unld_id`, `unld_data` and `unld_last` give the oldest buffer's next beat. Beats come out in beat order, and `unld_last` marks beat `BEATS`-1.
- R6: An unload request while `head_ready` is 0 is ignored: `unld_valid` stays 0 in the next cycle and no beat is consumed.
- R7: On the edge that registers the final unload beat, the buffer becomes free and its `buf_ready` bit becomes 0.
- R8: A fill on a system tick whose `fill_id` is free or is NUM_BUFS or larger raises `err_unrsvd` for exactly the next cycle. The data is dropped.
- R9: A fill on a system tick to a buffer that is complete but not yet released raises `err_ovwr` for exactly the next cycle. The buffer's stored beats stay unchanged.
- R10: `sys_tick` is high when the base phase is a multiple of `SYS_RATIO`, and `cache_tick` when it is a multiple of `CACHE_RATIO`. The phase counts 0 up to the least common multiple of the two ratios minus one, and starts at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | output | 1 | System-domain edge marker |
| cache_tick | output | 1 | Cache-domain edge marker |
| rsv_req | input | 1 | Reserve a buffer (system side) |
| rsv_avail | output | 1 | At least one buffer is free |
| rsv_id | output | ID_W | Buffer a reservation would take |
| fill_valid | input | 1 | Fill beat present (system side) |
| fill_id | input | ID_W | Target buffer of the fill beat |
| fill_data | input | DATA_W | Fill beat payload |
| err_unrsvd | output | 1 | One-cycle pulse: fill to unreserved buffer |
| err_ovwr | output | 1 | One-cycle pulse: fill to undrained buffer |
| buf_ready | output | NUM_BUFS | Cache-visible fill-complete flags |
| head_ready | output | 1 | Oldest reserved buffer is visible as complete |
| unld_req | input | 1 | Unload one beat (cache side) |
| unld_valid | output | 1 | Unload beat present |
| unld_id | output | ID_W | Buffer of the unload beat |
| unld_data | output | DATA_W | Unload beat payload |
| unld_last | output | 1 | Final beat of the block |

## Verification
The embedded properties check several rules on every cycle. A ready flag may rise only on a common edge. An unload beat may appear only after a granted request. A reservation must take the buffer that was offered. The final beat must clear its ready flag. The two error pulses may never coincide, and the order queue may neither overflow nor underflow. Other behaviour shows only in the bench's scenarios, which run against a cycle model: that data comes out in the same order and with the same content it went in, that reservation order is kept across buffers, and that dropped fills really leave a buffer's contents untouched.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

   typedef enum logic [1:0] {
      BUF_FREE = 2'd0,
      BUF_RSVD = 2'd1,
      BUF_FULL = 2'd2
   } buf_state_e;

   function automatic int rbp_gcd(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int rbp_lcm(input int a, input int b);
      return (a / rbp_gcd(a, b)) * b;
   endfunction

   function automatic int rbp_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rbp_ratio_gen.sv
module rbp_ratio_gen
   import rbp_pkg::*;
#(
   parameter int SYS_RATIO   = 3,
   parameter int CACHE_RATIO = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic sys_tick,
   output logic cache_tick,
   output logic common_edge
);
   localparam int PERIOD = rbp_lcm(SYS_RATIO, CACHE_RATIO);
   localparam int CNT_W  = rbp_width(PERIOD);

   if (SYS_RATIO < 1 || CACHE_RATIO < 1) begin : g_bad_ratio
      $error("rbp_ratio_gen: ratios must be at least 1");
   end

   logic [CNT_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (phase_q == CNT_W'(PERIOD - 1)) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   always_comb begin
      sys_tick    = ((int'(phase_q) % SYS_RATIO) == 0);
      cache_tick  = ((int'(phase_q) % CACHE_RATIO) == 0);
      common_edge = (phase_q == '0);
   end

   if (SYS_RATIO > 1) begin : g_sys_gap
      a_r10_sys_gap : assert property (@(posedge clk) disable iff (!rst_n)
         sys_tick |=> !sys_tick)
         else $error("a_r10_sys_gap");
   end

endmodule

// File: rtl/rbp_order_fifo.sv
module rbp_order_fifo #(
   parameter int DEPTH = 3,
   parameter int ID_W  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [ID_W-1:0] push_id,
   input  logic            pop,
   output logic [ID_W-1:0] head_id,
   output logic            empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rbp_order_fifo: DEPTH must be at least 1");
   end

   logic [ID_W-1:0]  slot_q [DEPTH];
   logic [PTR_W-1:0] wr_q;
   logic [PTR_W-1:0] rd_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else begin
         if (push) begin
            slot_q[wr_q] <= push_id;
            wr_q         <= bump(wr_q);
         end
         if (pop) rd_q <= bump(rd_q);
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign head_id = slot_q[rd_q];
   assign empty   = (cnt_q == '0);

   a_r2_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CNT_W'(DEPTH)) || pop)
      else $error("a_r2_no_overflow");

   a_r5_no_underflow : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty)
      else $error("a_r5_no_underflow");

endmodule

// File: rtl/rbp_store.sv
module rbp_store #(
   parameter int ENTRIES = 12,
   parameter int DATA_W  = 128,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   if ((1 << ADDR_W) < ENTRIES) begin : g_bad_addr
      $error("rbp_store: ADDR_W too narrow for ENTRIES");
   end

   logic [DATA_W-1:0] mem_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/rbp_read_pool.sv
module rbp_read_pool
   import rbp_pkg::*;
#(
   parameter int NUM_BUFS    = 3,
   parameter int BLOCK_BYTES = 64,
   parameter int BEAT_BYTES  = 16,
   parameter int SYS_RATIO   = 3,
   parameter int CACHE_RATIO = 2,
   localparam int ID_W       = rbp_width(NUM_BUFS),
   localparam int DATA_W     = BEAT_BYTES * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                sys_tick,
   output logic                cache_tick,
   input  logic                rsv_req,
   output logic                rsv_avail,
   output logic [ID_W-1:0]     rsv_id,
   input  logic                fill_valid,
   input  logic [ID_W-1:0]     fill_id,
   input  logic [DATA_W-1:0]   fill_data,
   output logic                err_unrsvd,
   output logic                err_ovwr,
   output logic [NUM_BUFS-1:0] buf_ready,
   output logic                head_ready,
   input  logic                unld_req,
   output logic                unld_valid,
   output logic [ID_W-1:0]     unld_id,
   output logic [DATA_W-1:0]   unld_data,
   output logic                unld_last
);
   localparam int BEATS   = BLOCK_BYTES / BEAT_BYTES;
   localparam int BEAT_W  = rbp_width(BEATS);
   localparam int ENTRIES = NUM_BUFS * BEATS;
   localparam int ADDR_W  = rbp_width(ENTRIES);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

   if (NUM_BUFS < 1) begin : g_bad_bufs
      $error("rbp_read_pool: NUM_BUFS must be at least 1");
   end
   if (BEAT_BYTES < 1 || (BLOCK_BYTES % BEAT_BYTES) != 0) begin : g_bad_beat
      $error("rbp_read_pool: BLOCK_BYTES must be a multiple of BEAT_BYTES");
   end

   // domain ticks
   logic common;

   rbp_ratio_gen #(
      .SYS_RATIO  (SYS_RATIO),
      .CACHE_RATIO(CACHE_RATIO)
   ) u_ratio (
      .clk        (clk),
      .rst_n      (rst_n),
      .sys_tick   (sys_tick),
      .cache_tick (cache_tick),
      .common_edge(common)
   );

   // per-buffer state gathered into arrays
   buf_state_e        st_all  [NUM_BUFS];
   logic [BEAT_W-1:0] fbt_all [NUM_BUFS];
   logic              rdy_all [NUM_BUFS];
   logic [NUM_BUFS-1:0] free_vec;

   always_comb begin
      for (int i = 0; i < NUM_BUFS; i++) begin
         free_vec[i]  = (st_all[i] == BUF_FREE);
         buf_ready[i] = rdy_all[i];
      end
   end

   // reservation: lowest free index wins
   always_comb begin
      rsv_id = '0;
      for (int i = NUM_BUFS - 1; i >= 0; i--) begin
         if (free_vec[i]) rsv_id = ID_W'(i);
      end
   end
   assign rsv_avail = |free_vec;

   logic rsv_take;
   assign rsv_take = sys_tick && rsv_req && rsv_avail;

   // fill classification
   logic              id_ok;
   logic [ID_W-1:0]   fill_idx;
   buf_state_e        fill_st;
   logic [BEAT_W-1:0] fill_beat;
   logic              fill_hit;
   logic              fill_bad;
   logic              fill_busy;

   always_comb begin
      id_ok     = (int'(fill_id) < NUM_BUFS);
      fill_idx  = id_ok ? fill_id : '0;
      fill_st   = id_ok ? st_all[fill_idx] : BUF_FREE;
      fill_beat = fbt_all[fill_idx];
      fill_hit  = sys_tick && fill_valid && (fill_st == BUF_RSVD);
      fill_bad  = sys_tick && fill_valid && (fill_st == BUF_FREE);
      fill_busy = sys_tick && fill_valid && (fill_st == BUF_FULL);
   end

   // unload order
   logic [ID_W-1:0]   head_id;
   logic              ord_empty;
   logic [BEAT_W-1:0] ubeat_q;
   logic              unld_fire;
   logic              unld_end;

   assign head_ready = !ord_empty && rdy_all[head_id];
   assign unld_fire  = cache_tick && unld_req && head_ready;
   assign unld_end   = unld_fire && (ubeat_q == LAST_BEAT);

   rbp_order_fifo #(
      .DEPTH(NUM_BUFS),
      .ID_W (ID_W)
   ) u_order (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (rsv_take),
      .push_id(rsv_id),
      .pop    (unld_end),
      .head_id(head_id),
      .empty  (ord_empty)
   );

   // beat storage
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] raddr;
   logic [DATA_W-1:0] rdata;

   assign waddr = ADDR_W'(int'(fill_idx) * BEATS + int'(fill_beat));
   assign raddr = ADDR_W'(int'(head_id) * BEATS + int'(ubeat_q));

   rbp_store #(
      .ENTRIES(ENTRIES),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk  (clk),
      .we   (fill_hit),
      .waddr(waddr),
      .wdata(fill_data),
      .raddr(raddr),
      .rdata(rdata)
   );

   // per-buffer control
   for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
      buf_state_e        st_q;
      logic [BEAT_W-1:0] fbeat_q;
      logic              rdy_q;
      logic              me_rsv;
      logic              me_fill;
      logic              me_rel;

      assign me_rsv  = rsv_take  && (rsv_id   == ID_W'(g));
      assign me_fill = fill_hit  && (fill_idx == ID_W'(g));
      assign me_rel  = unld_end  && (head_id  == ID_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q    <= BUF_FREE;
            fbeat_q <= '0;
            rdy_q   <= 1'b0;
         end else begin
            if (me_rsv) st_q <= BUF_RSVD;
            if (me_fill) begin
               if (fbeat_q == LAST_BEAT) begin
                  st_q    <= BUF_FULL;
                  fbeat_q <= '0;
               end else begin
                  fbeat_q <= fbeat_q + 1'b1;
               end
            end
            if (me_rel) st_q <= BUF_FREE;
            if (me_rel)      rdy_q <= 1'b0;
            else if (common) rdy_q <= (st_q == BUF_FULL);
         end
      end

      assign st_all[g]  = st_q;
      assign fbt_all[g] = fbeat_q;
      assign rdy_all[g] = rdy_q;
   end

   // unload beat counter and registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ubeat_q    <= '0;
         unld_valid <= 1'b0;
         unld_id    <= '0;
         unld_data  <= '0;
         unld_last  <= 1'b0;
         err_unrsvd <= 1'b0;
         err_ovwr   <= 1'b0;
      end else begin
         err_unrsvd <= fill_bad;
         err_ovwr   <= fill_busy;
         unld_valid <= unld_fire;
         if (unld_fire) begin
            unld_id   <= head_id;
            unld_data <= rdata;
            unld_last <= (ubeat_q == LAST_BEAT);
            ubeat_q   <= (ubeat_q == LAST_BEAT) ? '0 : ubeat_q + 1'b1;
         end
      end
   end

   // assertions
   a_r2_rsv_taken : assert property (@(posedge clk) disable iff (!rst_n)
      rsv_take |=> !free_vec[$past(rsv_id)])
      else $error("a_r2_rsv_taken");

   a_r4_ready_on_common : assert property (@(posedge clk) disable iff (!rst_n)
      ((buf_ready & ~$past(buf_ready)) != '0) |-> $past(common))
      else $error("a_r4_ready_on_common");

   a_r6_valid_after_grant : assert property (@(posedge clk) disable iff (!rst_n)
      unld_valid |-> $past(cache_tick && unld_req && head_ready))
      else $error("a_r6_valid_after_grant");

   a_r7_release_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (unld_valid && unld_last) |-> !buf_ready[unld_id])
      else $error("a_r7_release_clears");

   a_r8_err_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_unrsvd, err_ovwr}))
      else $error("a_r8_err_exclusive");

endmodule

// File: tb/tb_rbp_read_pool.sv
module tb_rbp_read_pool;
   localparam int NB    = 3;
   localparam int BLK   = 64;
   localparam int BB    = 16;
   localparam int SR    = 3;
   localparam int CR    = 2;
   localparam int BEATS = BLK / BB;
   localparam int DW    = BB * 8;
   localparam int IW    = 2;
   localparam int PER   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sys_tick, cache_tick;
   logic rsv_req = 1'b0;
   logic rsv_avail;
   logic [IW-1:0] rsv_id;
   logic fill_valid = 1'b0;
   logic [IW-1:0] fill_id = '0;
   logic [DW-1:0] fill_data = '0;
   logic err_unrsvd, err_ovwr;
   logic [NB-1:0] buf_ready;
   logic head_ready;
   logic unld_req = 1'b0;
   logic unld_valid;
   logic [IW-1:0] unld_id;
   logic [DW-1:0] unld_data;
   logic unld_last;

   always #2.5 clk = ~clk;

   rbp_read_pool #(
      .NUM_BUFS(NB), .BLOCK_BYTES(BLK), .BEAT_BYTES(BB),
      .SYS_RATIO(SR), .CACHE_RATIO(CR)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .cache_tick(cache_tick),
      .rsv_req(rsv_req), .rsv_avail(rsv_avail), .rsv_id(rsv_id),
      .fill_valid(fill_valid), .fill_id(fill_id), .fill_data(fill_data),
      .err_unrsvd(err_unrsvd), .err_ovwr(err_ovwr), .buf_ready(buf_ready),
      .head_ready(head_ready), .unld_req(unld_req), .unld_valid(unld_valid),
      .unld_id(unld_id), .unld_data(unld_data), .unld_last(unld_last)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference model: 0 free, 1 reserved, 2 complete
   int m_st [NB];
   int pre_st [NB];
   int m_fb [NB];
   bit m_rdy [NB];
   logic [DW-1:0] m_mem [NB][BEATS];
   int m_q [$];
   int m_ub, m_cnt;
   bit m_uv, m_ul, m_eu, m_eo;
   int m_uid;
   logic [DW-1:0] m_ud;
   int n_eu = 0, n_eo = 0, n_rel = 0;

   function automatic int low_free();
      for (int i = 0; i < NB; i++) if (m_st[i] == 0) return i;
      return -1;
   endfunction

   function automatic bit head_rdy();
      return (m_q.size() > 0) && m_rdy[m_q[0]];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) begin
            m_st[i] = 0; m_fb[i] = 0; m_rdy[i] = 1'b0;
         end
         m_q.delete();
         m_ub = 0; m_cnt = 0; m_uv = 0; m_ul = 0; m_eu = 0; m_eo = 0;
         m_uid = 0; m_ud = '0;
      end else begin
         bit st, ct, cm, hr;
         int fi, fid, rel;
         st = (m_cnt % SR) == 0;
         ct = (m_cnt % CR) == 0;
         cm = (m_cnt == 0);
         hr = head_rdy();
         fi = low_free();
         rel = -1;
         for (int i = 0; i < NB; i++) pre_st[i] = m_st[i];
         m_eu = 0; m_eo = 0; m_uv = 0;
         if (st && fill_valid) begin
            fid = int'(fill_id);
            if (fid >= NB || m_st[fid] == 0) m_eu = 1;
            else if (m_st[fid] == 2) m_eo = 1;
            else begin
               m_mem[fid][m_fb[fid]] = fill_data;
               if (m_fb[fid] == BEATS - 1) begin m_st[fid] = 2; m_fb[fid] = 0; end
               else m_fb[fid]++;
            end
         end
         if (st && rsv_req && fi >= 0) begin
            m_st[fi] = 1;
            m_q.push_back(fi);
         end
         if (ct && unld_req && hr) begin
            m_uv = 1;
            m_uid = m_q[0];
            m_ud = m_mem[m_uid][m_ub];
            m_ul = (m_ub == BEATS - 1);
            if (m_ul) begin
               rel = m_uid; m_st[m_uid] = 0; m_ub = 0; void'(m_q.pop_front());
            end else m_ub++;
         end
         if (cm) for (int i = 0; i < NB; i++) m_rdy[i] = (pre_st[i] == 2);
         if (rel >= 0) m_rdy[rel] = 1'b0;
         m_cnt = (m_cnt == PER - 1) ? 0 : m_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [NB-1:0] er;
      int fi;
      fi = low_free();
      for (int i = 0; i < NB; i++) er[i] = m_rdy[i];
      chk("R10 sys_tick", DW'(sys_tick), DW'((m_cnt % SR) == 0));
      chk("R10 cache_tick", DW'(cache_tick), DW'((m_cnt % CR) == 0));
      chk("R2 rsv_avail", DW'(rsv_avail), DW'(fi >= 0));
      if (fi >= 0) chk("R2 rsv_id", DW'(rsv_id), DW'(fi));
      chk("R4 R7 buf_ready", DW'(buf_ready), DW'(er));
      chk("R6 head_ready", DW'(head_ready), DW'(head_rdy()));
      chk("R5 R6 unld_valid", DW'(unld_valid), DW'(m_uv));
      if (m_uv) begin
         chk("R5 unld_id", DW'(unld_id), DW'(m_uid));
         chk("R3 R5 unld_data", unld_data, m_ud);
         chk("R5 unld_last", DW'(unld_last), DW'(m_ul));
         if (m_ul) n_rel++;
      end
      chk("R8 err_unrsvd", DW'(err_unrsvd), DW'(m_eu));
      chk("R9 err_ovwr", DW'(err_ovwr), DW'(m_eo));
      if (m_eu) n_eu++;
      if (m_eo) n_eo++;
   endtask

   task automatic drive(input int k);
      int pick;
      int cand [$];
      if (k < 8) begin
         // directed: fills to unreserved buffers, unload with nothing ready
         rsv_req    = 1'b0;
         fill_valid = 1'b1;
         fill_id    = IW'(k % 4);
         fill_data  = {$urandom, $urandom, $urandom, $urandom};
         unld_req   = 1'b1;
         return;
      end
      rsv_req  = ($urandom_range(0, 99) < 35);
      unld_req = ($urandom_range(0, 99) < 55);
      fill_valid = ($urandom_range(0, 99) < 60);
      for (int i = 0; i < NB; i++) if (m_st[i] == 1) cand.push_back(i);
      if (cand.size() > 0 && $urandom_range(0, 99) < 80)
         pick = cand[$urandom_range(0, cand.size() - 1)];
      else
         pick = $urandom_range(0, 3);
      fill_id   = IW'(pick);
      fill_data = {$urandom, $urandom, $urandom, $urandom};
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 rsv_avail", DW'(rsv_avail), DW'(1));
      chk("R1 rsv_id", DW'(rsv_id), DW'(0));
      chk("R1 buf_ready", DW'(buf_ready), DW'(0));
      chk("R1 head_ready", DW'(head_ready), DW'(0));
      chk("R1 unld_valid", DW'(unld_valid), DW'(0));
      chk("R1 errors", DW'({err_unrsvd, err_ovwr}), DW'(0));
      for (int k = 0; k < 6000; k++) begin
         drive(k);
         @(negedge clk);
         compare_all();
      end
      chk("R8 unreserved fills seen", DW'(n_eu > 0), DW'(1));
      chk("R9 overwrite fills seen", DW'(n_eo > 0), DW'(1));
      chk("R7 releases seen", DW'(n_rel > 2), DW'(1));
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule